// File: doc/BRIEF.md
# Reservation-Tracking Atomic Memory Unit

This block is a small word-addressed memory placed behind several processor ports. Each port can issue a plain load or store. It can also issue the primitives that software uses to build locks and counters: a linked load paired with a conditional store, an indivisible swap, and a fetch-and-increment. Each port holds a single reservation, made of an address and a valid flag. The reservation is opened by a linked load. It is torn down when any other port writes that word, so that a later conditional store from the owner fails and the software retries.

A port raises its request and holds its operation, address and write data until it sees its grant. One request is served per cycle. Ports are chosen in rotating order, starting after the port served last. The result appears on the shared read-data bus one cycle after the grant, and a per-port response strobe marks the owner. Because every operation completes in its granted cycle, each operation is atomic with respect to all the others.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads 0, no grant is given and no response strobe is high.
- R2: Opcode 0 (load) returns the addressed word. Opcode 1 (store) writes the write data and returns 0.
- R3: Opcode 2 (linked load) returns the addressed word and records a valid reservation on that address for the issuing port.
- R4: Opcode 3 (conditional store) writes the data and returns 1 when the issuing port holds a valid reservation on that same address.
- R5: A store, swap, fetch-and-increment or successful conditional store from another port to the reserved address clears the reservation. The owner's following conditional store then returns 0 and leaves the word unchanged.
- R6: A conditional store from a port with no valid reservation, or with a reservation on a different address, returns 0 and writes nothing.
- R7: Opcode 4 (swap) returns the old word and writes the data in the same operation. With 0 meaning free and 1 meaning held, a swap of 1 that returns 0 has taken the lock, and one that returns 1 has not.
- R8: Opcode 5 (fetch-and-increment) returns the old word and stores the old word plus one, wrapping to 0 past the largest value.
- R9: At most one requesting port is granted per cycle. The search starts at the port after the one granted last, and at port 0 after reset.
- R10: The response strobe of exactly the granted port, together with the result on the read-data bus, is high in the cycle after the grant.
- R11: Every conditional store clears the issuing port's own reservation, so a second conditional store without a new linked load fails.
- R12: A write by another port to a different address leaves a reservation intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NPORTS | Request pending, one bit per port |
| req_op | input | 3*NPORTS | Opcode per port, port p at bits [3p+2:3p] |
| req_addr | input | AW*NPORTS | Word address per port |
| req_wdata | input | DW*NPORTS | Write or swap data per port |
| req_grant | output | NPORTS | One-hot grant, valid in the request cycle |
| rsp_valid | output | NPORTS | Response strobe, one cycle after grant |
| rsp_rdata | output | DW | Result of the operation granted last cycle |

## Verification
The bench builds the unit with four ports, a sixteen-word memory and eight-bit words. The narrow word lets fetch-and-increment wrap from the top value to zero in two operations. Four ports let two-way races show the rotation both in the middle of the port range and across its end. Directed scenarios cover reservations broken by stores and increments, reservations left alone by writes elsewhere, and lock handover through swap.

// File: rtl/amu_pkg.sv
// Package: shared opcode encoding for the atomic memory unit.
// Assumes the 3-bit opcode field on each request port; unused codes act as loads.
package amu_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LINK  = 3'd2,
        OP_COND  = 3'd3,
        OP_SWAP  = 3'd4,
        OP_FINC  = 3'd5
    } amu_op_e;
endpackage

// File: rtl/amu_rr_arb.sv
// Module: rotating-priority arbiter. It grants one requester per cycle.
// The search starts at the index after the last winner, and at 0 after reset.
// Assumes NPORTS >= 2.
module amu_rr_arb #(
    parameter int NPORTS = 4,
    localparam int PW = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] req,
    output logic [NPORTS-1:0] grant,
    output logic              win_valid,
    output logic [PW-1:0]     win_idx
);
    logic [PW-1:0] start_q;

    // Purpose: find the first requester at or after the start pointer.
    always_comb begin
        grant     = '0;
        win_valid = 1'b0;
        win_idx   = '0;
        for (int k = 0; k < NPORTS; k++) begin
            int c;
            c = int'(start_q) + k;
            if (c >= NPORTS) c = c - NPORTS;
            if (!win_valid && req[c]) begin
                win_valid = 1'b1;
                win_idx   = PW'(c);
                grant[c]  = 1'b1;
            end
        end
    end

    // Purpose: move the start pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (win_valid) begin
            start_q <= (int'(win_idx) == NPORTS - 1) ? '0 : win_idx + 1'b1;
        end
    end
endmodule

// File: rtl/amu_resv.sv
// Module: reservation table, one address and valid flag per port.
// Assumes a single granted operation per cycle; wr_en marks a real write.
module amu_resv #(
    parameter int NPORTS = 4,
    parameter int AW = 4,
    localparam int PW = $clog2(NPORTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           g_valid,
    input  logic [PW-1:0]  g_port,
    input  amu_pkg::amu_op_e g_op,
    input  logic [AW-1:0]  g_addr,
    input  logic           wr_en,
    output logic           hit
);
    import amu_pkg::*;

    logic          rv [NPORTS];
    logic [AW-1:0] ra [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_slot
        // Purpose: open, close or clear this port's reservation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rv[p] <= 1'b0;
                ra[p] <= '0;
            end else if (g_valid) begin
                if (int'(g_port) == p) begin
                    if (g_op == OP_LINK) begin
                        rv[p] <= 1'b1;
                        ra[p] <= g_addr;
                    end else if (g_op == OP_COND) begin
                        rv[p] <= 1'b0;
                    end
                end else if (wr_en && ra[p] == g_addr) begin
                    rv[p] <= 1'b0;
                end
            end
        end
    end

    // Purpose: report whether the winner holds a reservation on its address.
    always_comb begin
        hit = rv[g_port] && (ra[g_port] == g_addr);
    end
endmodule

// File: rtl/amu_exec.sv
// Module: word store plus operation datapath. It performs the read-modify-write
// of the granted operation in one cycle. Assumes the reservation result is
// valid in the same cycle.
module amu_exec #(
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             g_valid,
    input  amu_pkg::amu_op_e g_op,
    input  logic [AW-1:0]    g_addr,
    input  logic [DW-1:0]    g_wdata,
    input  logic             hit,
    output logic             wr_en,
    output logic [DW-1:0]    result,
    output logic [DW-1:0]    words [DEPTH]
);
    import amu_pkg::*;

    logic [DW-1:0] old_w;
    logic [DW-1:0] new_w;
    logic          do_wr;

    // Purpose: decode the operation into a write decision, new word and result.
    always_comb begin
        old_w  = words[g_addr];
        new_w  = g_wdata;
        do_wr  = 1'b0;
        result = old_w;
        case (g_op)
            OP_STORE: begin do_wr = 1'b1; result = '0; end
            OP_COND:  begin do_wr = hit; result = DW'(hit); end
            OP_SWAP:  begin do_wr = 1'b1; end
            OP_FINC:  begin do_wr = 1'b1; new_w = old_w + DW'(1); end
            default:  begin do_wr = 1'b0; end
        endcase
        wr_en = g_valid && do_wr;
    end

    // Purpose: hold the memory words, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[g_addr] <= new_w;
        end
    end
endmodule

// File: rtl/atomic_mem_unit.sv
// Module: top of the atomic memory unit. It arbitrates port requests, runs
// the winner's operation against memory and reservations, and registers the
// result. Assumes requesters hold their fields stable until granted.
module atomic_mem_unit #(
    parameter int NPORTS = 4,
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int PW = $clog2(NPORTS),
    localparam int DEPTH = 1 << AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    req_valid,
    input  logic [3*NPORTS-1:0]  req_op,
    input  logic [AW*NPORTS-1:0] req_addr,
    input  logic [DW*NPORTS-1:0] req_wdata,
    output logic [NPORTS-1:0]    req_grant,
    output logic [NPORTS-1:0]    rsp_valid,
    output logic [DW-1:0]        rsp_rdata
);
    import amu_pkg::*;

    logic             g_valid;
    logic [PW-1:0]    g_port;
    amu_op_e          g_op;
    logic [AW-1:0]    g_addr;
    logic [DW-1:0]    g_wdata;
    logic             res_hit;
    logic             wr_en;
    logic [DW-1:0]    result;
    logic [DW-1:0]    mem_view [DEPTH];

    amu_rr_arb #(.NPORTS(NPORTS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_valid),
        .grant(req_grant), .win_valid(g_valid), .win_idx(g_port)
    );

    // Purpose: route the winning port's fields to the datapath.
    always_comb begin
        g_op    = amu_op_e'(req_op[int'(g_port)*3 +: 3]);
        g_addr  = req_addr[int'(g_port)*AW +: AW];
        g_wdata = req_wdata[int'(g_port)*DW +: DW];
    end

    amu_resv #(.NPORTS(NPORTS), .AW(AW)) u_resv (
        .clk(clk), .rst_n(rst_n), .g_valid(g_valid), .g_port(g_port),
        .g_op(g_op), .g_addr(g_addr), .wr_en(wr_en), .hit(res_hit)
    );

    amu_exec #(.AW(AW), .DW(DW)) u_exec (
        .clk(clk), .rst_n(rst_n), .g_valid(g_valid), .g_op(g_op),
        .g_addr(g_addr), .g_wdata(g_wdata), .hit(res_hit),
        .wr_en(wr_en), .result(result), .words(mem_view)
    );

    // Purpose: register the response strobe and result one cycle after grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_grant;
            if (g_valid) rsp_rdata <= result;
        end
    end
endmodule

// File: rtl/amu_checker.sv
// Module: property checker bound to the atomic memory unit.
// Assumes it sees the top's internal winner fields and memory view.
module amu_checker #(
    parameter int NPORTS = 4,
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] req_valid,
    input logic [NPORTS-1:0] req_grant,
    input logic [NPORTS-1:0] rsp_valid,
    input logic              g_valid,
    input logic [2:0]        g_op,
    input logic [AW-1:0]     g_addr,
    input logic [DW-1:0]     g_wdata,
    input logic              res_hit,
    input logic [DW-1:0]     mem_view [DEPTH]
);
    // R9
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    // R9
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant & ~req_valid) == '0);

    // R10
    rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(req_grant));

    // R6
    failed_cond_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_valid && g_op == 3'd3 && !res_hit) |=>
            mem_view[$past(g_addr)] == $past(mem_view[g_addr]));

    // R7
    swap_writes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_valid && g_op == 3'd4) |=> mem_view[$past(g_addr)] == $past(g_wdata));

    // R8
    finc_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_valid && g_op == 3'd5) |=>
            mem_view[$past(g_addr)] == $past(mem_view[g_addr]) + DW'(1));
endmodule

bind atomic_mem_unit amu_checker #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .g_valid(g_valid), .g_op(g_op), .g_addr(g_addr),
    .g_wdata(g_wdata), .res_hit(res_hit), .mem_view(mem_view)
);

// File: tb/atomic_mem_unit_test.sv
// Bench: directed scenarios for the atomic memory unit, one task each.
module atomic_mem_unit_test;
    localparam int N = 4;
    localparam int AW = 4;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [3*N-1:0]    req_op = '0;
    logic [AW*N-1:0]   req_addr = '0;
    logic [DW*N-1:0]   req_wdata = '0;
    logic [N-1:0]      req_grant;
    logic [N-1:0]      rsp_valid;
    logic [DW-1:0]     rsp_rdata;

    int n_checks = 0;
    int n_fail = 0;

    atomic_mem_unit #(.NPORTS(N), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input int p, input int op, input int a, input int d);
        req_op[p*3 +: 3]     = 3'(op);
        req_addr[p*AW +: AW] = AW'(a);
        req_wdata[p*DW +: DW] = DW'(d);
        req_valid[p]         = 1'b1;
    endtask

    // Issue one uncontended operation and return its result.
    task automatic do_op(input int p, input int op, input int a, input int d,
                         output int res);
        @(negedge clk);
        set_req(p, op, a, d);
        #1;
        chk("R9 grant to lone requester", int'(req_grant), 1 << p);
        @(posedge clk);
        #1;
        req_valid[p] = 1'b0;
        chk("R10 response strobe", int'(rsp_valid), 1 << p);
        res = int'(rsp_rdata);
    endtask

    task automatic t_reset;
        chk("R1 no grant after reset", int'(req_grant), 0);
        chk("R1 no response after reset", int'(rsp_valid), 0);
    endtask

    task automatic t_race;
        // R9: after reset the pointer is 0; ports 1 and 2 race a swap.
        @(negedge clk);
        set_req(1, 4, 12, 1);
        set_req(2, 4, 12, 1);
        #1;
        chk("R9 first winner port1", int'(req_grant), 4'b0010);
        @(posedge clk);
        #1;
        chk("R9 next cycle winner port2", int'(req_grant), 4'b0100);
        chk("R10 port1 response", int'(rsp_valid), 4'b0010);
        chk("R7 port1 takes free lock", int'(rsp_rdata), 0);
        req_valid[1] = 1'b0;
        @(posedge clk);
        #1;
        req_valid[2] = 1'b0;
        chk("R10 port2 response", int'(rsp_valid), 4'b0100);
        chk("R7 port2 sees held lock", int'(rsp_rdata), 1);
        // R9: the pointer now sits at 3, so port 3 beats port 0 (wrap).
        @(negedge clk);
        set_req(0, 5, 13, 0);
        set_req(3, 5, 13, 0);
        #1;
        chk("R9 wrap winner port3", int'(req_grant), 4'b1000);
        @(posedge clk);
        #1;
        chk("R9 then port0", int'(req_grant), 4'b0001);
        chk("R8 port3 old value", int'(rsp_rdata), 0);
        req_valid[3] = 1'b0;
        @(posedge clk);
        #1;
        req_valid[0] = 1'b0;
        chk("R8 port0 old value", int'(rsp_rdata), 1);
    endtask

    task automatic t_load_store;
        int r;
        do_op(0, 0, 3, 0, r);    chk("R1 memory cleared", r, 0);
        do_op(0, 1, 2, 8'h5A, r); chk("R2 store returns 0", r, 0);
        do_op(1, 0, 2, 0, r);    chk("R2 load sees store", r, 8'h5A);
    endtask

    task automatic t_link_ok;
        int r;
        do_op(1, 1, 4, 8'h07, r);
        do_op(1, 2, 4, 0, r);     chk("R3 linked load value", r, 8'h07);
        do_op(1, 3, 4, 8'h33, r); chk("R4 conditional succeeds", r, 1);
        do_op(2, 0, 4, 0, r);     chk("R4 word written", r, 8'h33);
        do_op(1, 3, 4, 8'h44, r); chk("R11 second conditional fails", r, 0);
        do_op(2, 0, 4, 0, r);     chk("R11 word kept", r, 8'h33);
    endtask

    task automatic t_link_broken;
        int r;
        do_op(2, 2, 6, 0, r);
        do_op(3, 1, 6, 8'h11, r);
        do_op(2, 3, 6, 8'h22, r); chk("R5 store breaks reservation", r, 0);
        do_op(0, 0, 6, 0, r);     chk("R5 word unchanged", r, 8'h11);
        do_op(2, 2, 6, 0, r);     chk("R3 relink value", r, 8'h11);
        do_op(0, 5, 6, 0, r);     chk("R8 increment old value", r, 8'h11);
        do_op(2, 3, 6, 8'h22, r); chk("R5 increment breaks reservation", r, 0);
        do_op(0, 0, 6, 0, r);     chk("R5 word is incremented value", r, 8'h12);
    endtask

    task automatic t_no_resv;
        int r;
        do_op(3, 3, 7, 8'h99, r); chk("R6 no reservation fails", r, 0);
        do_op(0, 0, 7, 0, r);     chk("R6 no write", r, 0);
        do_op(3, 2, 7, 0, r);
        do_op(3, 3, 8, 8'h99, r); chk("R6 other address fails", r, 0);
        do_op(0, 0, 8, 0, r);     chk("R6 other address unwritten", r, 0);
    endtask

    task automatic t_other_addr;
        int r;
        do_op(0, 2, 9, 0, r);
        do_op(1, 1, 10, 8'h44, r);
        do_op(0, 3, 9, 8'h55, r); chk("R12 reservation survives", r, 1);
        do_op(1, 0, 9, 0, r);     chk("R12 word written", r, 8'h55);
    endtask

    task automatic t_lock;
        int r;
        do_op(1, 4, 5, 1, r); chk("R7 acquire free lock", r, 0);
        do_op(2, 4, 5, 1, r); chk("R7 lock already held", r, 1);
        do_op(1, 1, 5, 0, r);
        do_op(2, 4, 5, 1, r); chk("R7 acquire after release", r, 0);
    endtask

    task automatic t_finc_wrap;
        int r;
        do_op(3, 1, 11, 8'hFE, r);
        do_op(3, 5, 11, 0, r); chk("R8 returns FE", r, 8'hFE);
        do_op(3, 5, 11, 0, r); chk("R8 returns FF", r, 8'hFF);
        do_op(3, 0, 11, 0, r); chk("R8 wraps to zero", r, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_race();
        t_load_store();
        t_link_ok();
        t_link_broken();
        t_no_resv();
        t_other_addr();
        t_lock();
        t_finc_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule